// File: doc/BRIEF.md
# Miss-Entry Snoop Decision Logic

This block sits beside one outstanding miss entry of a cache and decides what that entry does when a snoop to the same block arrives. It takes the entry's current standing as inputs: whether its request has been issued, whether that request is still held up further down the hierarchy, whether a modified copy is expected, and whether the primary target queue wants a writable copy. It also takes the attributes of the snoop. It first works out whether the snoop logically comes before or after the entry's own request. From that it produces a handled result, a request to store the snoop as a target for later replay, the response flags to place on the snoop, and rewrite strobes that tell the two target queues to turn buffered upgrades into full exclusive reads.

The entry keeps two flags of its own. The post-invalidate flag means the block will be lost once the fill completes. The post-downgrade flag means the block will be left read-only. Snoops set these flags, and marking the entry in service clears them. The snoop's attributes pass through one register stage. Every decision output is valid in the cycle after the snoop is presented, and the flag updates land on the clock edge that ends that cycle. Packet copying and the storage of targets belong to the neighbouring logic.

Top module: `snoop_decide`

## Requirements
- R1: A decided snoop whose needs-writable and invalidate attributes differ drives `proto_err_o` high in its decision cycle. When the two attributes agree, `proto_err_o` stays low.
- R2: The snoop precedes the entry when `ent_in_service_i` is low, or when `snp_express_i` and `ent_dn_pending_i` are both high. A preceding snoop gives `handled_o`=0, no save, no response flags and no flag change. Both `rewrite_prim_o` and `rewrite_defer_o` equal the snoop's needs-writable attribute.
- R3: When the entry's request comes first, `rewrite_prim_o` stays low and `rewrite_defer_o` follows the snoop's needs-writable attribute.
- R4: When the entry's request comes first and post-invalidate is already set, `handled_o`=1. No save, no response flag and no flag change follow.
- R5: When the entry comes first, post-invalidate is clear, and either a modified copy is awaited or the snoop is an invalidate, `save_o`=1. `save_order_o` then carries the snoop's order tag, and `save_pending_o` = `ent_dn_pending_i` AND `ent_prim_needs_wr_i`. Without a save, `save_order_o` is zero.
- R6: `will_respond_o` is high only for a saved snoop where a modified copy is awaited, the snoop needs a response, and the snoop is not a plain invalidate.
- R7: A saved snoop while a modified copy is awaited drives both `cache_resp_o` and `had_writable_o` high. Otherwise both stay low.
- R8: A saved snoop that needs writability sets post-invalidate at the edge that ends its decision cycle.
- R9: When the entry comes first and post-invalidate is clear, a snoop that neither needs writability nor is uncacheable drives `has_sharers_o` and sets post-downgrade. This holds whether or not the snoop is saved.
- R10: The decision outputs come up in the cycle after the edge that samples `snp_valid_i` and are low at all other times. The flags change on the next edge after that.
- R11: `mark_svc_i` high at an edge clears both flags at that edge. It wins over a snoop whose flag updates fall on the same edge.
- R12: After reset both flags are clear and `dec_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_valid_i | input | 1 | A snoop is presented this cycle |
| snp_needs_wr_i | input | 1 | Snoop asks for a writable copy |
| snp_inval_i | input | 1 | Snoop invalidates other copies |
| snp_express_i | input | 1 | Snoop is an express snoop |
| snp_need_resp_i | input | 1 | Snoop expects a response |
| snp_uncached_i | input | 1 | Snoop's request is uncacheable |
| snp_plain_inv_i | input | 1 | Snoop is a plain invalidate with no data |
| snp_order_i | input | ORD_W | Order tag of the snoop |
| ent_in_service_i | input | 1 | Entry's request has been issued |
| ent_dn_pending_i | input | 1 | Entry's request is still buffered downstream |
| ent_await_mod_i | input | 1 | Entry expects a modified copy |
| ent_prim_needs_wr_i | input | 1 | Primary target queue needs a writable copy |
| mark_svc_i | input | 1 | Entry is being marked in service |
| dec_valid_o | output | 1 | Decision outputs are valid |
| handled_o | output | 1 | Entry takes part in the snoop |
| proto_err_o | output | 1 | Attribute mismatch error |
| save_o | output | 1 | Store the snoop as a target |
| save_pending_o | output | 1 | Pending mark for the stored target |
| save_order_o | output | ORD_W | Order tag for the stored target |
| will_respond_o | output | 1 | Entry will respond to the stored snoop later |
| cache_resp_o | output | 1 | Mark the snoop as answered by a cache |
| had_writable_o | output | 1 | Mark that the responder held a writable copy |
| has_sharers_o | output | 1 | Mark that sharers exist |
| rewrite_prim_o | output | 1 | Rewrite upgrades in the primary queue |
| rewrite_defer_o | output | 1 | Rewrite upgrades in the deferred queue |
| post_inv_o | output | 1 | Post-invalidate flag |
| post_dgr_o | output | 1 | Post-downgrade flag |

## Verification
The decision is tried with an unissued entry and with an express snoop while the request is held downstream. These two cases separate the "snoop comes first" path, which only produces rewrite strobes, from the ordered path. On the ordered path the patterns vary the awaited-modified state, the invalidate and plain-invalidate kinds, the need for a response and uncacheability. This separates replaying as the ordering point from recording an invalidation and from a bare downgrade. Runs with post-invalidate already set, with mismatched attributes, and with marking in service on the flag-update edge show the early exit, the error flag and the clearing priority.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  // Attributes carried by one snoop through the capture stage.
  typedef struct packed {
    logic needs_wr;
    logic inval;
    logic express;
    logic need_resp;
    logic uncached;
    logic plain_inv;
  } snp_attr_t;

  localparam int unsigned SNP_ATTR_W = $bits(snp_attr_t);

endpackage

// File: rtl/snoop_capture.sv
module snoop_capture
  import snoop_pkg::*;
#(
  parameter int unsigned ORD_W  = 8,
  parameter bit          IN_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             v_i,
  input  snp_attr_t        attr_i,
  input  logic [ORD_W-1:0] ord_i,
  output logic             v_o,
  output snp_attr_t        attr_o,
  output logic [ORD_W-1:0] ord_o
);

  generate
    if (IN_REG) begin : g_reg
      logic             v_q;
      snp_attr_t        attr_q;
      logic [ORD_W-1:0] ord_q;
      snp_attr_t        attr_d;
      logic [ORD_W-1:0] ord_d;

      // Payload only loads with a valid snoop.
      always_comb begin
        attr_d = attr_q;
        ord_d  = ord_q;
        if (v_i) begin
          attr_d = attr_i;
          ord_d  = ord_i;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q    <= 1'b0;
          attr_q <= '0;
          ord_q  <= '0;
        end else begin
          v_q    <= v_i;
          attr_q <= attr_d;
          ord_q  <= ord_d;
        end
      end

      assign v_o    = v_q;
      assign attr_o = attr_q;
      assign ord_o  = ord_q;
    end else begin : g_pass
      assign v_o    = v_i;
      assign attr_o = attr_i;
      assign ord_o  = ord_i;
    end
  endgenerate

endmodule

// File: rtl/snoop_order.sv
module snoop_order (
  input  logic clk,
  input  logic rst_n,
  input  logic v_i,
  input  logic needs_wr_i,
  input  logic inval_i,
  input  logic express_i,
  input  logic in_service_i,
  input  logic dn_pending_i,
  output logic precede_o,
  output logic handled_o,
  output logic proto_err_o,
  output logic rewrite_prim_o,
  output logic rewrite_defer_o
);

  logic snoop_first;

  always_comb begin
    snoop_first     = !in_service_i || (express_i && dn_pending_i);
    precede_o       = v_i && snoop_first;
    handled_o       = v_i && !snoop_first;
    proto_err_o     = v_i && (needs_wr_i != inval_i);
    rewrite_prim_o  = v_i && snoop_first && needs_wr_i;
    rewrite_defer_o = v_i && needs_wr_i;
  end

  // R2 R3
  prim_rewrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewrite_prim_o |-> (rewrite_defer_o && !handled_o));

endmodule

// File: rtl/snoop_action.sv
module snoop_action (
  input  logic clk,
  input  logic rst_n,
  input  logic handled_i,
  input  logic post_inv_i,
  input  logic needs_wr_i,
  input  logic inval_i,
  input  logic need_resp_i,
  input  logic uncached_i,
  input  logic plain_inv_i,
  input  logic await_mod_i,
  input  logic dn_pending_i,
  input  logic prim_needs_wr_i,
  output logic save_o,
  output logic save_pending_o,
  output logic will_respond_o,
  output logic cache_resp_o,
  output logic had_writable_o,
  output logic has_sharers_o,
  output logic set_inv_o,
  output logic set_dgr_o
);

  logic active;

  always_comb begin
    active         = handled_i && !post_inv_i;
    save_o         = active && (await_mod_i || inval_i);
    save_pending_o = save_o && dn_pending_i && prim_needs_wr_i;
    will_respond_o = save_o && await_mod_i && need_resp_i && !plain_inv_i;
    cache_resp_o   = save_o && await_mod_i;
    had_writable_o = save_o && await_mod_i;
    set_inv_o      = save_o && needs_wr_i;
    set_dgr_o      = active && !needs_wr_i && !uncached_i;
    has_sharers_o  = set_dgr_o;
  end

  // R6 R7
  respond_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    will_respond_o |-> (cache_resp_o && save_o));

endmodule

// File: rtl/post_flags.sv
module post_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_i,
  input  logic set_inv_i,
  input  logic set_dgr_i,
  output logic post_inv_o,
  output logic post_dgr_o
);

  logic inv_q, dgr_q;
  logic inv_d, dgr_d;
  logic flag_en;

  always_comb begin
    flag_en = mark_i || set_inv_i || set_dgr_i;
    inv_d   = inv_q;
    dgr_d   = dgr_q;
    if (mark_i) begin
      inv_d = 1'b0;
      dgr_d = 1'b0;
    end else begin
      inv_d = inv_q || set_inv_i;
      dgr_d = dgr_q || set_dgr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inv_q <= 1'b0;
      dgr_q <= 1'b0;
    end else if (flag_en) begin
      inv_q <= inv_d;
      dgr_q <= dgr_d;
    end
  end

  assign post_inv_o = inv_q;
  assign post_dgr_o = dgr_q;

  // R11
  mark_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mark_i |=> (!post_inv_o && !post_dgr_o));

endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
  import snoop_pkg::*;
#(
  parameter int unsigned ORD_W  = 8,
  parameter bit          IN_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_valid_i,
  input  logic             snp_needs_wr_i,
  input  logic             snp_inval_i,
  input  logic             snp_express_i,
  input  logic             snp_need_resp_i,
  input  logic             snp_uncached_i,
  input  logic             snp_plain_inv_i,
  input  logic [ORD_W-1:0] snp_order_i,
  input  logic             ent_in_service_i,
  input  logic             ent_dn_pending_i,
  input  logic             ent_await_mod_i,
  input  logic             ent_prim_needs_wr_i,
  input  logic             mark_svc_i,
  output logic             dec_valid_o,
  output logic             handled_o,
  output logic             proto_err_o,
  output logic             save_o,
  output logic             save_pending_o,
  output logic [ORD_W-1:0] save_order_o,
  output logic             will_respond_o,
  output logic             cache_resp_o,
  output logic             had_writable_o,
  output logic             has_sharers_o,
  output logic             rewrite_prim_o,
  output logic             rewrite_defer_o,
  output logic             post_inv_o,
  output logic             post_dgr_o
);

  snp_attr_t        attr_in, attr_c;
  logic             v_c;
  logic [ORD_W-1:0] ord_c;
  logic             precede;
  logic             set_inv, set_dgr;

  always_comb begin
    attr_in.needs_wr  = snp_needs_wr_i;
    attr_in.inval     = snp_inval_i;
    attr_in.express   = snp_express_i;
    attr_in.need_resp = snp_need_resp_i;
    attr_in.uncached  = snp_uncached_i;
    attr_in.plain_inv = snp_plain_inv_i;
  end

  snoop_capture #(.ORD_W(ORD_W), .IN_REG(IN_REG)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .v_i    (snp_valid_i),
    .attr_i (attr_in),
    .ord_i  (snp_order_i),
    .v_o    (v_c),
    .attr_o (attr_c),
    .ord_o  (ord_c)
  );

  snoop_order u_ord (
    .clk             (clk),
    .rst_n           (rst_n),
    .v_i             (v_c),
    .needs_wr_i      (attr_c.needs_wr),
    .inval_i         (attr_c.inval),
    .express_i       (attr_c.express),
    .in_service_i    (ent_in_service_i),
    .dn_pending_i    (ent_dn_pending_i),
    .precede_o       (precede),
    .handled_o       (handled_o),
    .proto_err_o     (proto_err_o),
    .rewrite_prim_o  (rewrite_prim_o),
    .rewrite_defer_o (rewrite_defer_o)
  );

  snoop_action u_act (
    .clk             (clk),
    .rst_n           (rst_n),
    .handled_i       (handled_o),
    .post_inv_i      (post_inv_o),
    .needs_wr_i      (attr_c.needs_wr),
    .inval_i         (attr_c.inval),
    .need_resp_i     (attr_c.need_resp),
    .uncached_i      (attr_c.uncached),
    .plain_inv_i     (attr_c.plain_inv),
    .await_mod_i     (ent_await_mod_i),
    .dn_pending_i    (ent_dn_pending_i),
    .prim_needs_wr_i (ent_prim_needs_wr_i),
    .save_o          (save_o),
    .save_pending_o  (save_pending_o),
    .will_respond_o  (will_respond_o),
    .cache_resp_o    (cache_resp_o),
    .had_writable_o  (had_writable_o),
    .has_sharers_o   (has_sharers_o),
    .set_inv_o       (set_inv),
    .set_dgr_o       (set_dgr)
  );

  post_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .mark_i     (mark_svc_i),
    .set_inv_i  (set_inv),
    .set_dgr_i  (set_dgr),
    .post_inv_o (post_inv_o),
    .post_dgr_o (post_dgr_o)
  );

  assign dec_valid_o  = v_c;
  assign save_order_o = save_o ? ord_c : '0;

  // R4
  inv_blocks_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && post_inv_o) |-> !save_o);

  // R8
  save_sets_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && attr_c.needs_wr && !mark_svc_i) |=> post_inv_o);

  // R2
  precede_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    precede |-> (!save_o && !has_sharers_o && !handled_o));

endmodule

// File: tb/tb_snoop_decide.sv
module tb_snoop_decide;

  localparam int unsigned ORD_W      = 4;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned EXP_W      = ORD_W + 10;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             snp_valid_i, snp_needs_wr_i, snp_inval_i, snp_express_i;
  logic             snp_need_resp_i, snp_uncached_i, snp_plain_inv_i;
  logic [ORD_W-1:0] snp_order_i;
  logic             ent_in_service_i, ent_dn_pending_i, ent_await_mod_i;
  logic             ent_prim_needs_wr_i, mark_svc_i;
  logic             dec_valid_o, handled_o, proto_err_o, save_o, save_pending_o;
  logic [ORD_W-1:0] save_order_o;
  logic             will_respond_o, cache_resp_o, had_writable_o, has_sharers_o;
  logic             rewrite_prim_o, rewrite_defer_o, post_inv_o, post_dgr_o;

  int n_vec = 0;
  int n_bad = 0;
  logic [EXP_W-1:0] exp_q[$];
  string            tag_q[$];
  logic             m_inv, m_dgr;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_decide #(.ORD_W(ORD_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .snp_valid_i(snp_valid_i), .snp_needs_wr_i(snp_needs_wr_i),
    .snp_inval_i(snp_inval_i), .snp_express_i(snp_express_i),
    .snp_need_resp_i(snp_need_resp_i), .snp_uncached_i(snp_uncached_i),
    .snp_plain_inv_i(snp_plain_inv_i), .snp_order_i(snp_order_i),
    .ent_in_service_i(ent_in_service_i), .ent_dn_pending_i(ent_dn_pending_i),
    .ent_await_mod_i(ent_await_mod_i), .ent_prim_needs_wr_i(ent_prim_needs_wr_i),
    .mark_svc_i(mark_svc_i),
    .dec_valid_o(dec_valid_o), .handled_o(handled_o), .proto_err_o(proto_err_o),
    .save_o(save_o), .save_pending_o(save_pending_o), .save_order_o(save_order_o),
    .will_respond_o(will_respond_o), .cache_resp_o(cache_resp_o),
    .had_writable_o(had_writable_o), .has_sharers_o(has_sharers_o),
    .rewrite_prim_o(rewrite_prim_o), .rewrite_defer_o(rewrite_defer_o),
    .post_inv_o(post_inv_o), .post_dgr_o(post_dgr_o)
  );

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected decision for every valid decision cycle.
  always @(negedge clk) begin
    if (rst_n && dec_valid_o) begin
      logic [EXP_W-1:0] got;
      got = {handled_o, proto_err_o, save_o, save_pending_o, will_respond_o,
             cache_resp_o, had_writable_o, has_sharers_o, rewrite_prim_o,
             rewrite_defer_o, save_order_o};
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected decision actual=%h expected=none", got);
      end else begin
        logic [EXP_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s decision actual=%h expected=%h", t, got, e);
        end
      end
    end
  end

  // Driver: computes the expectation, pushes it, applies the snoop.
  task automatic snoop(input string tag, input logic ins, input logic dp,
                       input logic am, input logic pnw, input logic nw,
                       input logic inv, input logic ex, input logic nr,
                       input logic unc, input logic pl,
                       input logic [ORD_W-1:0] ord, input logic mark);
    logic prec, hnd, act, sv, spn, wr, cr, sh, si, sd;
    prec = !ins || (ex && dp);
    hnd  = !prec;
    act  = hnd && !m_inv;
    sv   = act && (am || inv);
    spn  = sv && dp && pnw;
    wr   = sv && am && nr && !pl;
    cr   = sv && am;
    si   = sv && nw;
    sd   = act && !nw && !unc;
    sh   = sd;
    exp_q.push_back({hnd, (nw != inv), sv, spn, wr, cr, cr, sh,
                     (prec && nw), nw, (sv ? ord : {ORD_W{1'b0}})});
    tag_q.push_back(tag);
    @(posedge clk); #1;
    ent_in_service_i = ins; ent_dn_pending_i = dp; ent_await_mod_i = am;
    ent_prim_needs_wr_i = pnw;
    snp_valid_i = 1'b1; snp_needs_wr_i = nw; snp_inval_i = inv;
    snp_express_i = ex; snp_need_resp_i = nr; snp_uncached_i = unc;
    snp_plain_inv_i = pl; snp_order_i = ord;
    @(negedge clk);
    check_bit("R10 no early decision", dec_valid_o, 1'b0);
    @(posedge clk); #1;
    snp_valid_i = 1'b0;
    mark_svc_i  = mark;
    @(posedge clk); #1;
    mark_svc_i = 1'b0;
    if (mark) begin
      m_inv = 1'b0; m_dgr = 1'b0;
    end else begin
      m_inv = m_inv || si;
      m_dgr = m_dgr || sd;
    end
    @(negedge clk);
    check_bit({tag, " post_inv R8 R10"}, post_inv_o, m_inv);
    check_bit({tag, " post_dgr R9 R10"}, post_dgr_o, m_dgr);
  endtask

  task automatic mark_only();
    @(posedge clk); #1;
    mark_svc_i = 1'b1;
    @(posedge clk); #1;
    mark_svc_i = 1'b0;
    m_inv = 1'b0; m_dgr = 1'b0;
    @(negedge clk);
    check_bit("R11 mark clears inv", post_inv_o, 1'b0);
    check_bit("R11 mark clears dgr", post_dgr_o, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    snp_valid_i = 0; snp_needs_wr_i = 0; snp_inval_i = 0; snp_express_i = 0;
    snp_need_resp_i = 0; snp_uncached_i = 0; snp_plain_inv_i = 0;
    snp_order_i = '0; ent_in_service_i = 0; ent_dn_pending_i = 0;
    ent_await_mod_i = 0; ent_prim_needs_wr_i = 0; mark_svc_i = 0;
    m_inv = 1'b0; m_dgr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_bit("R12 reset post_inv", post_inv_o, 1'b0);
    check_bit("R12 reset post_dgr", post_dgr_o, 1'b0);
    check_bit("R12 reset dec_valid", dec_valid_o, 1'b0);

    //          tag                    ins dp am pnw nw inv ex nr unc pl ord   mark
    snoop("R2 unissued writable",      0, 0, 0, 0,  1, 1,  0, 1, 0,  0, 4'h1, 0);
    snoop("R2 unissued read",          0, 0, 0, 0,  0, 0,  0, 1, 0,  0, 4'h2, 0);
    snoop("R2 express downstream",     1, 1, 0, 0,  0, 0,  1, 1, 0,  0, 4'h3, 0);
    snoop("R9 read downgrade",         1, 0, 0, 0,  0, 0,  0, 1, 0,  0, 4'h4, 0);
    snoop("R11 uncached with mark",    1, 0, 0, 0,  0, 0,  0, 1, 1,  0, 4'h5, 1);
    snoop("R5 R6 R7 owner read",       1, 1, 1, 1,  0, 0,  0, 1, 0,  0, 4'h6, 0);
    snoop("R6 R3 plain invalidate",    1, 0, 1, 0,  1, 1,  0, 1, 0,  1, 4'h7, 0);
    snoop("R4 inv pending writable",   1, 0, 0, 0,  1, 1,  0, 1, 0,  0, 4'h8, 0);
    snoop("R4 inv pending read",       1, 0, 1, 1,  0, 0,  0, 1, 0,  0, 4'h9, 0);
    snoop("R2 precede over inv",       0, 0, 1, 0,  1, 1,  0, 1, 0,  0, 4'hA, 0);
    mark_only();
    snoop("R5 R7 invalidate no owner", 1, 1, 0, 0,  1, 1,  0, 1, 0,  0, 4'hB, 0);
    mark_only();
    snoop("R1 writable not inval",     1, 0, 0, 0,  1, 0,  0, 0, 0,  0, 4'hC, 0);
    snoop("R1 inval not writable",     1, 0, 0, 0,  0, 1,  0, 1, 0,  0, 4'hD, 0);
    snoop("R9 R11 dgr cleared",        1, 0, 0, 0,  0, 0,  0, 0, 0,  0, 4'hE, 1);

    repeat (3) @(negedge clk);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing decisions actual=%0d expected=0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule